// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a network controller (and the host) and a small on-board packet RAM. It takes a 24-bit byte address and turns it into a RAM word address by looking it up in a writable table of page entries. The top nibble of the address is discarded. The next ten bits pick one of 1024 entries. The low ten bits are the byte offset inside a 1024-byte page and pass through unchanged.

Each entry holds three things: a physical frame number, a byte-order flag and a flag that sends the access to memory on the expansion connector instead of on-board memory. The flag word tells the data path whether to exchange the two bytes of each 16-bit word. Controller traffic and host traffic into the RAM window use the same table. A source tag travels with each request so the caller can tell them apart.

Software fills the table through a 16-bit word port, one entry per index, and can read entries back. A typical setup maps every index straight to its own frame. It then aliases the last entry, which covers the fixed boot-pointer address at the top of the space, onto frame 0.

Top module: `pmap_translator`

## Requirements
- R1: After reset every map entry reads back as 0x0000. A translation through any entry then yields frame 0, byte swap active, on-board memory and no range error. Right after reset `xl_valid` and `map_rvalid` are 0.
- R2: Address bits 23:20 have no effect. Bits 19:10 select the entry. The word address is `{frame, addr[9:1]}`, where frame is entry bits 11:0, and `xl_byte_sel` equals addr[0].
- R3: `xl_swap` is the inverse of entry bit 15. Bit 15 clear means little-endian order, so the two bytes of each word are exchanged.
- R4: `xl_ext` equals entry bit 13. 1 selects expansion-bus memory and 0 selects on-board memory.
- R5: `xl_range_err` is 1 exactly when on-board memory is selected and the frame number is 256 or above. It is never 1 when expansion memory is selected.
- R6: The outputs are registered with one cycle of latency. `xl_valid` is high in the cycle after `req_valid`. When `xl_valid` is low, all translation output fields are 0.
- R7: A map write is used by any translation issued in a later cycle. A translation issued in the same cycle as a write to its entry uses the old contents.
- R8: When `map_rd` is high, `map_rdata` holds the entry at `map_idx` one cycle later, with `map_rvalid` high. When a read and a write hit the same entry in the same cycle, the read returns the old value. With no read, `map_rdata` is 0.
- R9: Entry 1023 is programmable like any other. Aliasing it to frame 0 with big-endian order maps address 0xFFFFF4 to word address 0x1FA with no swap.
- R10: `xl_host` returns the `req_host` tag of the request one cycle later. Host and controller requests are translated through the same table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_host | input | 1 | Request source: 1 host, 0 controller |
| req_addr | input | 24 | Byte address to translate |
| map_wr | input | 1 | Write `map_wdata` to entry `map_idx` |
| map_rd | input | 1 | Read entry `map_idx` |
| map_idx | input | 10 | Entry index for map access |
| map_wdata | input | 16 | Entry write data |
| map_rdata | output | 16 | Entry read data |
| map_rvalid | output | 1 | Read data valid |
| xl_valid | output | 1 | Translated request valid |
| xl_host | output | 1 | Source tag of translated request |
| xl_word_addr | output | 21 | Translated RAM word address |
| xl_byte_sel | output | 1 | Byte within word (addr bit 0) |
| xl_swap | output | 1 | Exchange bytes of each data word |
| xl_ext | output | 1 | Access goes to expansion-bus memory |
| xl_range_err | output | 1 | On-board frame number out of range |

## Verification
Directed cases come first. They read a freshly reset table, alias the top entry and translate the boot-pointer address, and write frames just above and below the on-board limit with each memory select. This separates a wrong range compare from a wrong memory-select gate. Random traffic then mixes writes, reads and requests on a small set of indices with random upper address nibbles. It repeatedly hits same-cycle write/translate and write/read collisions, which exposes whether the old or the new entry is used. Every field is checked against a reference table kept in the bench.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
    localparam int ENTRY_W   = 16;
    localparam int ORDER_BIT = 15;
    localparam int EXT_BIT   = 13;
    localparam int FRAME_W   = 12;

    typedef struct packed {
        logic               big_end;
        logic               ext;
        logic [FRAME_W-1:0] frame;
    } entry_t;

    function automatic entry_t unpack_entry(input logic [ENTRY_W-1:0] raw);
        entry_t e;
        e.big_end = raw[ORDER_BIT];
        e.ext     = raw[EXT_BIT];
        e.frame   = raw[FRAME_W-1:0];
        return e;
    endfunction
endpackage

// File: rtl/pmap_table.sv
module pmap_table
    import pmap_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx_a,
    output logic [ENTRY_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]   rd_idx_b,
    output logic [ENTRY_W-1:0] rd_data_b
);
    localparam int NENT = 1 << IDX_W;

    logic [ENTRY_W-1:0] tbl_q [NENT];

    // one register per entry; each loads only when addressed
    for (genvar g = 0; g < NENT; g++) begin : g_ent
        logic [ENTRY_W-1:0] ent_d;
        always_comb begin
            ent_d = tbl_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) ent_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) tbl_q[g] <= '0;
            else        tbl_q[g] <= ent_d;
        end
    end

    assign rd_data_a = tbl_q[rd_idx_a];
    assign rd_data_b = tbl_q[rd_idx_b];
endmodule

// File: rtl/pmap_decode.sv
module pmap_decode
    import pmap_pkg::*;
#(
    parameter int OFF_W          = 10,
    parameter int ONBOARD_FRAMES = 256,
    localparam int WADDR_W       = FRAME_W + OFF_W - 1
) (
    input  logic [ENTRY_W-1:0] raw_entry,
    input  logic [OFF_W-1:0]   offset,
    output logic [WADDR_W-1:0] word_addr,
    output logic               byte_sel,
    output logic               swap,
    output logic               ext,
    output logic               range_err
);
    entry_t e;
    logic   spare_unused;

    always_comb begin
        e         = unpack_entry(raw_entry);
        word_addr = {e.frame, offset[OFF_W-1:1]};
        byte_sel  = offset[0];
        swap      = ~e.big_end;
        ext       = e.ext;
        range_err = ~e.ext && (32'(e.frame) >= 32'(ONBOARD_FRAMES));
    end

    assign spare_unused = raw_entry[14] ^ raw_entry[12];
endmodule

// File: rtl/pmap_translator.sv
module pmap_translator
    import pmap_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int IDX_W          = 10,
    parameter int OFF_W          = 10,
    parameter int ONBOARD_FRAMES = 256,
    localparam int WADDR_W       = FRAME_W + OFF_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_host,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               map_wr,
    input  logic               map_rd,
    input  logic [IDX_W-1:0]   map_idx,
    input  logic [ENTRY_W-1:0] map_wdata,
    output logic [ENTRY_W-1:0] map_rdata,
    output logic               map_rvalid,
    output logic               xl_valid,
    output logic               xl_host,
    output logic [WADDR_W-1:0] xl_word_addr,
    output logic               xl_byte_sel,
    output logic               xl_swap,
    output logic               xl_ext,
    output logic               xl_range_err
);
    localparam int IDX_LO = OFF_W;
    localparam int IDX_HI = OFF_W + IDX_W - 1;

    typedef struct packed {
        logic               valid;
        logic               host;
        logic [WADDR_W-1:0] waddr;
        logic               bsel;
        logic               swap;
        logic               ext;
        logic               err;
        logic               rvalid;
        logic [ENTRY_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]   xl_idx;
    logic [ENTRY_W-1:0] xl_entry, hst_entry;
    logic [WADDR_W-1:0] dec_waddr;
    logic               dec_bsel, dec_swap, dec_ext, dec_err;
    logic               top_unused;

    assign xl_idx     = req_addr[IDX_HI:IDX_LO];
    assign top_unused = ^req_addr[ADDR_W-1:IDX_HI+1];

    pmap_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_wr),
        .wr_idx   (map_idx),
        .wr_data  (map_wdata),
        .rd_idx_a (xl_idx),
        .rd_data_a(xl_entry),
        .rd_idx_b (map_idx),
        .rd_data_b(hst_entry)
    );

    pmap_decode #(.OFF_W(OFF_W), .ONBOARD_FRAMES(ONBOARD_FRAMES)) u_decode (
        .raw_entry(xl_entry),
        .offset   (req_addr[OFF_W-1:0]),
        .word_addr(dec_waddr),
        .byte_sel (dec_bsel),
        .swap     (dec_swap),
        .ext      (dec_ext),
        .range_err(dec_err)
    );

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.valid = 1'b1;
            st_d.host  = req_host;
            st_d.waddr = dec_waddr;
            st_d.bsel  = dec_bsel;
            st_d.swap  = dec_swap;
            st_d.ext   = dec_ext;
            st_d.err   = dec_err;
        end
        if (map_rd) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = hst_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xl_valid     = st_q.valid;
    assign xl_host      = st_q.host;
    assign xl_word_addr = st_q.waddr;
    assign xl_byte_sel  = st_q.bsel;
    assign xl_swap      = st_q.swap;
    assign xl_ext       = st_q.ext;
    assign xl_range_err = st_q.err;
    assign map_rvalid   = st_q.rvalid;
    assign map_rdata    = st_q.rdata;
endmodule

// File: rtl/pmap_translator_chk.sv
module pmap_translator_chk #(
    parameter int ADDR_W  = 24,
    parameter int OFF_W   = 10,
    parameter int WADDR_W = 21
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_host,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               map_rd,
    input logic               map_rvalid,
    input logic               xl_valid,
    input logic               xl_host,
    input logic [WADDR_W-1:0] xl_word_addr,
    input logic               xl_byte_sel,
    input logic               xl_ext,
    input logic               xl_range_err
);
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> xl_valid);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!xl_valid && !xl_range_err && !xl_ext));
    a_r2_byte_sel: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xl_byte_sel == $past(req_addr[0])));
    a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xl_word_addr[OFF_W-2:0] == $past(req_addr[OFF_W-1:1])));
    a_r10_src_tag: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xl_host == $past(req_host)));
    a_r5_ext_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        xl_ext |-> !xl_range_err);
    a_r8_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd |=> map_rvalid);
    a_r8_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !map_rd |=> !map_rvalid);
endmodule

bind pmap_translator pmap_translator_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WADDR_W(WADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_host(req_host),
    .req_addr(req_addr), .map_rd(map_rd), .map_rvalid(map_rvalid),
    .xl_valid(xl_valid), .xl_host(xl_host), .xl_word_addr(xl_word_addr),
    .xl_byte_sel(xl_byte_sel), .xl_ext(xl_ext), .xl_range_err(xl_range_err)
);

// File: tb/tb_pmap_translator.sv
module tb_pmap_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_host = 1'b0;
    logic [23:0] req_addr = '0;
    logic        map_wr = 1'b0, map_rd = 1'b0;
    logic [9:0]  map_idx = '0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rdata;
    logic        map_rvalid, xl_valid, xl_host, xl_byte_sel, xl_swap, xl_ext, xl_range_err;
    logic [20:0] xl_word_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] model [1024];

    // pending expectations for the next output cycle
    logic        e_valid, e_host, e_bsel, e_swap, e_ext, e_err, e_rvalid;
    logic [20:0] e_waddr;
    logic [15:0] e_rdata;
    string       e_tag;

    always #10 clk = ~clk;

    pmap_translator dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_host(req_host),
        .req_addr(req_addr), .map_wr(map_wr), .map_rd(map_rd), .map_idx(map_idx),
        .map_wdata(map_wdata), .map_rdata(map_rdata), .map_rvalid(map_rvalid),
        .xl_valid(xl_valid), .xl_host(xl_host), .xl_word_addr(xl_word_addr),
        .xl_byte_sel(xl_byte_sel), .xl_swap(xl_swap), .xl_ext(xl_ext),
        .xl_range_err(xl_range_err)
    );

    function automatic logic [20:0] exp_waddr(input logic [15:0] e, input logic [23:0] a);
        return {e[11:0], a[9:1]};
    endfunction

    function automatic logic exp_err(input logic [15:0] e);
        return !e[13] && (e[11:0] >= 12'd256);
    endfunction

    task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (%s): actual 0x%0h expected 0x%0h at %0t", req, nm, e_tag, act, exp, $time);
        end
    endtask

    task automatic check_pending();
        chk("R6",  "xl_valid",     32'(xl_valid),     32'(e_valid));
        chk("R10", "xl_host",      32'(xl_host),      32'(e_host));
        chk("R2",  "xl_word_addr", 32'(xl_word_addr), 32'(e_waddr));
        chk("R2",  "xl_byte_sel",  32'(xl_byte_sel),  32'(e_bsel));
        chk("R3",  "xl_swap",      32'(xl_swap),      32'(e_swap));
        chk("R4",  "xl_ext",       32'(xl_ext),       32'(e_ext));
        chk("R5",  "xl_range_err", 32'(xl_range_err), 32'(e_err));
        chk("R8",  "map_rvalid",   32'(map_rvalid),   32'(e_rvalid));
        chk("R8",  "map_rdata",    32'(map_rdata),    32'(e_rdata));
    endtask

    // check outputs of previous cycle, drive new inputs, predict, update model
    task automatic step(input logic rv, input logic rh, input logic [23:0] ra,
                        input logic wr, input logic rd, input logic [9:0] idx,
                        input logic [15:0] wd, input string tag);
        logic [15:0] ent;
        @(negedge clk);
        check_pending();
        req_valid = rv; req_host = rh; req_addr = ra;
        map_wr = wr; map_rd = rd; map_idx = idx; map_wdata = wd;
        ent      = model[ra[19:10]];
        e_tag    = tag;
        e_valid  = rv;
        e_host   = rv & rh;
        e_waddr  = rv ? exp_waddr(ent, ra) : '0;
        e_bsel   = rv & ra[0];
        e_swap   = rv & ~ent[15];
        e_ext    = rv & ent[13];
        e_err    = rv & exp_err(ent);
        e_rvalid = rd;
        e_rdata  = rd ? model[idx] : '0;
        if (wr) model[idx] = wd;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        for (int i = 0; i < 1024; i++) model[i] = '0;
        e_valid = 0; e_host = 0; e_waddr = '0; e_bsel = 0; e_swap = 0;
        e_ext = 0; e_err = 0; e_rvalid = 0; e_rdata = '0; e_tag = "R1 reset";
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state, then reset entries read as zero and translate to frame 0
        step(1, 0, 24'h0_0C_8A5, 0, 1, 10'd5,   16'h0, "R1 reset state");
        step(1, 1, 24'h3_FF_C01, 0, 1, 10'd1023, 16'h0, "R1 zero entry");
        // R9: alias top entry to frame 0, big-endian
        step(0, 0, 24'h0,        1, 0, 10'd1023, 16'h8000, "R9 program");
        step(1, 0, 24'hFFFFF4,   0, 1, 10'd1023, 16'h0, "R9 boot alias");
        // R7: write and translate same entry same cycle -> old, next -> new
        step(1, 0, 24'h0_01_402, 1, 0, 10'd5,   16'h2123, "R7 same cycle old");
        step(1, 0, 24'h0_01_402, 0, 0, 10'd0,   16'h0,    "R7 next cycle new");
        // R8: read and write same index same cycle -> old value
        step(0, 0, 24'h0,        1, 1, 10'd5,   16'h0077, "R8 collide");
        step(0, 0, 24'h0,        0, 1, 10'd5,   16'h0,    "R8 after write");
        // R5: out-of-range frame on-board vs expansion, boundary 255/256
        step(0, 0, 24'h0,        1, 0, 10'd7,   16'h0100, "R5 set 256");
        step(0, 0, 24'h0,        1, 0, 10'd8,   16'h80FF, "R5 set 255");
        step(0, 0, 24'h0,        1, 0, 10'd9,   16'h2FFF, "R5 set ext");
        step(1, 0, 24'h0_01_C00, 0, 0, 10'd0,   16'h0,    "R5 frame 256 onboard");
        step(1, 1, 24'h0_02_001, 0, 0, 10'd0,   16'h0,    "R5 frame 255");
        step(1, 0, 24'h0_02_7FF, 0, 0, 10'd0,   16'h0,    "R5 R4 ext frame 4095");
        // R2: top nibble ignored
        step(1, 0, 24'hA_01_C10, 0, 0, 10'd0,   16'h0,    "R2 top nibble");
        // random traffic on a small index set with random upper nibbles
        for (int n = 0; n < 4000; n++) begin
            logic [9:0]  ix, ax;
            logic [23:0] a;
            ix = ($urandom % 3 != 0) ? 10'($urandom % 8) : 10'($urandom);
            ax = ($urandom % 3 != 0) ? 10'($urandom % 8) : 10'($urandom);
            a  = {4'($urandom), ax, 10'($urandom)};
            step(($urandom % 4) != 0, 1'($urandom), a, ($urandom % 3) == 0,
                 ($urandom % 3) == 0, ix, 16'($urandom), "random R2 R7 R8 R10");
        end
        step(0, 0, 24'h0, 0, 0, 10'd0, 16'h0, "flush");
        finish_run();
    end
endmodule